// File: doc/BRIEF.md
# Block Transfer Sequencer

This block moves a group of registers to or from memory with one command. A 16-bit selection mask names the registers to move. A base address and four control bits set the transfer: direction (load or store), whether addresses grow or shrink from the base, whether the base is stepped before or after each access, and whether the final address is returned for base write-back. The sequencer then issues one word access per selected register. Each access comes with the matching register-file read or write strobe.

Register numbers and addresses always climb together, in every mode. For a shrinking transfer the sequencer first computes the lowest address the group will occupy, then walks upward from there. The memory and the register file are both treated as synchronous-read stores with one cycle of read latency. A load therefore writes the register file one cycle after its memory read. A store writes memory one cycle after its register-file read.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, mem_req_o, rf_rd_o, rf_we_o and base_we_o are all 0.
- R2: Only the registers whose mask bit is set are transferred, one per cycle, in ascending register number. The number of accesses equals the number of set bits.
- R3: Successive accesses of a transfer use addresses that rise by 4 from one access to the next. The lowest-numbered selected register therefore uses the lowest address.
- R4: With up_i=1 and pre_i=0, the first access is at base_i.
- R5: With up_i=1 and pre_i=1, the first access is at base_i+4.
- R6: With up_i=0 and pre_i=0, the first access is at base_i-4n+4, where n is the number of set bits.
- R7: With up_i=0 and pre_i=1, the first access is at base_i-4n.
- R8: With wb_i=1, base_we_o pulses together with done_o. At that point base_wdata_o is base_i+4n when up_i=1, or base_i-4n when up_i=0. With wb_i=0, base_we_o stays 0.
- R9: With load_i=1, a memory read (mem_req_o=1, mem_we_o=0) is issued for each register. One cycle later rf_we_o=1 with that register's index on rf_widx_o and mem_rdata_i on rf_wdata_o.
- R10: With load_i=0, rf_rd_o=1 is issued with the register index. One cycle later a memory write (mem_req_o=1, mem_we_o=1) goes to that register's address, with rf_rdata_i on mem_wdata_o.
- R11: start_i is sampled at edge E0. The first access appears after edge E1. done_o is high for exactly one cycle, after edge E(n+2). busy_o is high from E0 until that edge and is low while done_o is high.
- R12: A start with an all-zero mask raises err_o and done_o for one cycle after E0. It issues no memory or register-file access and no base write, and busy_o stays 0.
- R13: start_i and all command inputs are ignored while busy_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command strobe, accepted when idle |
| reglist_i | input | 16 | Register selection mask, bit i = register i |
| base_i | input | 32 | Base address |
| pre_i | input | 1 | 1: step before each access, 0: step after |
| up_i | input | 1 | 1: ascending from base, 0: descending |
| wb_i | input | 1 | Request base write-back |
| load_i | input | 1 | 1: memory to registers, 0: registers to memory |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle empty-mask error pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after request |
| rf_rd_o | output | 1 | Register-file read strobe |
| rf_ridx_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data, one cycle after strobe |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_widx_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| base_we_o | output | 1 | Base write-back strobe |
| base_wdata_o | output | 32 | Written-back base value |

## Verification
Every result has a fixed cycle relative to the start edge E0. The k-th access of either kind (k from 0) is visible after edge E(k+1). Its second half (the register write for a load, the memory write for a store) is visible after edge E(k+2). done_o, err_o and the write-back appear after E(n+2), or after E0 for an empty mask.

The bench samples at the falling edge that follows each of these rising edges. It compares every access against addresses and indices derived from the mask and mode, not from the design. One further cycle confirms that done_o has dropped. Once the run is over, the memory and register-file models are read back to confirm the data actually moved. While one run is active, the bench holds start_i high with different command inputs to show those inputs change nothing.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Direction of a transfer as seen from the register file.
  typedef enum logic {
    XFER_STORE = 1'b0,
    XFER_LOAD  = 1'b1
  } xfer_dir_e;

endpackage

// File: rtl/blk_popcount.sv
module blk_popcount #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] part [W+1];

  assign part[0] = '0;

  generate
    for (genvar g = 0; g < W; g++) begin : g_acc
      assign part[g+1] = part[g] + CW'(vec[g]);
    end
  endgenerate

  assign cnt = part[W];

endmodule

// File: rtl/blk_lowest_pick.sv
module blk_lowest_pick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  rest
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any  = |vec;
  assign rest = vec & (vec - W'(1));

endmodule

// File: rtl/blk_addr_plan.sv
module blk_addr_plan #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pre,
  input  logic              up,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_addr
);

  localparam int SH = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] low_end;

  assign span    = ADDR_W'(cnt) << SH;
  assign low_end = base - span;

  always_comb begin
    if (up) begin
      first_addr = pre ? base + STEP : base;
      final_addr = base + span;
    end else begin
      first_addr = pre ? low_end : low_end + STEP;
      final_addr = low_end;
    end
  end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int NREG       = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [NREG-1:0]           reglist_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic                      pre_i,
  input  logic                      up_i,
  input  logic                      wb_i,
  input  logic                      load_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic                      rf_rd_o,
  output logic [$clog2(NREG)-1:0]   rf_ridx_o,
  input  logic [DATA_W-1:0]         rf_rdata_i,
  output logic                      rf_we_o,
  output logic [$clog2(NREG)-1:0]   rf_widx_o,
  output logic [DATA_W-1:0]         rf_wdata_o,
  output logic                      base_we_o,
  output logic [ADDR_W-1:0]         base_wdata_o
);

  import blk_xfer_pkg::*;

  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_state_e        st;
  xfer_dir_e         dir;
  logic              wb_q;
  logic [NREG-1:0]   pend;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] fin_addr;

  // issue stage (A) and completion stage (B)
  logic              a_vld, a_last;
  logic [IDX_W-1:0]  a_idx;
  logic [ADDR_W-1:0] a_addr;
  logic              b_vld, b_last;
  logic [IDX_W-1:0]  b_idx;
  logic [ADDR_W-1:0] b_addr;

  logic              done_q, err_q, bwe_q;

  logic [CNT_W-1:0]  sel_cnt;
  logic [ADDR_W-1:0] plan_first, plan_final;
  logic              pick_any;
  logic [IDX_W-1:0]  pick_idx;
  logic [NREG-1:0]   pick_rest;

  blk_popcount #(.W(NREG), .CW(CNT_W)) u_cnt (
    .vec (reglist_i),
    .cnt (sel_cnt)
  );

  blk_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base       (base_i),
    .cnt        (sel_cnt),
    .pre        (pre_i),
    .up         (up_i),
    .first_addr (plan_first),
    .final_addr (plan_final)
  );

  blk_lowest_pick #(.W(NREG), .IW(IDX_W)) u_pick (
    .vec  (pend),
    .any  (pick_any),
    .idx  (pick_idx),
    .rest (pick_rest)
  );

  // control and stage registers
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEQ_IDLE;
      dir      <= XFER_STORE;
      wb_q     <= 1'b0;
      pend     <= '0;
      cur_addr <= '0;
      fin_addr <= '0;
      a_vld    <= 1'b0;
      a_last   <= 1'b0;
      a_idx    <= '0;
      a_addr   <= '0;
      b_vld    <= 1'b0;
      b_last   <= 1'b0;
      b_idx    <= '0;
      b_addr   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      bwe_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      bwe_q  <= 1'b0;

      b_vld  <= a_vld;
      b_last <= a_last;
      b_idx  <= a_idx;
      b_addr <= a_addr;

      a_vld  <= 1'b0;
      a_last <= 1'b0;

      unique case (st)
        SEQ_IDLE: begin
          if (start_i) begin
            if (reglist_i == '0) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              st       <= SEQ_RUN;
              pend     <= reglist_i;
              cur_addr <= plan_first;
              fin_addr <= plan_final;
              dir      <= load_i ? XFER_LOAD : XFER_STORE;
              wb_q     <= wb_i;
            end
          end
        end
        SEQ_RUN: begin
          if (pick_any) begin
            a_vld    <= 1'b1;
            a_last   <= (pick_rest == '0);
            a_idx    <= pick_idx;
            a_addr   <= cur_addr;
            cur_addr <= cur_addr + STEP;
            pend     <= pick_rest;
          end
          if (b_vld && b_last) begin
            st     <= SEQ_IDLE;
            done_q <= 1'b1;
            bwe_q  <= wb_q;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // port steering: a load reads memory in A and writes the register file in B;
  // a store reads the register file in A and writes memory in B
  always_comb begin
    if (dir == XFER_LOAD) begin
      mem_req_o  = a_vld;
      mem_we_o   = 1'b0;
      mem_addr_o = a_addr;
      rf_rd_o    = 1'b0;
      rf_we_o    = b_vld;
    end else begin
      mem_req_o  = b_vld;
      mem_we_o   = b_vld;
      mem_addr_o = b_addr;
      rf_rd_o    = a_vld;
      rf_we_o    = 1'b0;
    end
  end

  assign mem_wdata_o  = rf_rdata_i;
  assign rf_wdata_o   = mem_rdata_i;
  assign rf_ridx_o    = a_idx;
  assign rf_widx_o    = b_idx;
  assign busy_o       = (st == SEQ_RUN);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign base_we_o    = bwe_q;
  assign base_wdata_o = fin_addr;

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rf_rd_o,
  input logic              rf_we_o,
  input logic              base_we_o
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R12
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && !mem_req_o && !rf_rd_o && !rf_we_o && !base_we_o));

  // R8
  base_we_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    base_we_o |-> done_o);

  // R9
  load_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> $past(mem_req_o && !mem_we_o));

  // R10
  store_follows_rfread_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> $past(rf_rd_o));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $past(mem_req_o)) |->
      (mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES)));

  // R2
  access_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o || rf_rd_o || rf_we_o) |-> busy_o);

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
  .ADDR_W     (ADDR_W),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .rf_rd_o    (rf_rd_o),
  .rf_we_o    (rf_we_o),
  .base_we_o  (base_we_o)
);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] reglist_i = '0;
  logic [31:0] base_i = '0;
  logic        pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0, load_i = 1'b0;
  logic        busy_o, done_o, err_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i;
  logic        rf_rd_o, rf_we_o;
  logic [3:0]  rf_ridx_o, rf_widx_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        base_we_o;
  logic [31:0] base_wdata_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] bmem  [256];
  logic [31:0] rfile [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (
    .clk, .rst, .start_i, .reglist_i, .base_i, .pre_i, .up_i, .wb_i, .load_i,
    .busy_o, .done_o, .err_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .rf_rd_o, .rf_ridx_o, .rf_rdata_i, .rf_we_o, .rf_widx_o,
    .rf_wdata_o, .base_we_o, .base_wdata_o
  );

  // synchronous-read memory and register-file models
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 32'hA500_0000 + 32'(i * 7);
      for (int i = 0; i < 16; i++)  rfile[i] <= 32'h3C00_0000 + 32'(i * 257);
      mem_rdata_i <= '0;
      rf_rdata_i  <= '0;
    end else begin
      if (mem_req_o && !mem_we_o) mem_rdata_i <= bmem[mem_addr_o[9:2]];
      if (mem_req_o && mem_we_o)  bmem[mem_addr_o[9:2]] <= mem_wdata_o;
      if (rf_rd_o) rf_rdata_i <= rfile[rf_ridx_o];
      if (rf_we_o) rfile[rf_widx_o] <= rf_wdata_o;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_reset();
    check(busy_o == 1'b0,    "R1 busy",    32'(busy_o), 0);
    check(done_o == 1'b0,    "R1 done",    32'(done_o), 0);
    check(err_o == 1'b0,     "R1 err",     32'(err_o), 0);
    check(mem_req_o == 1'b0, "R1 mem_req", 32'(mem_req_o), 0);
    check(rf_rd_o == 1'b0,   "R1 rf_rd",   32'(rf_rd_o), 0);
    check(rf_we_o == 1'b0,   "R1 rf_we",   32'(rf_we_o), 0);
    check(base_we_o == 1'b0, "R1 base_we", 32'(base_we_o), 0);
  endtask

  task automatic run_xfer(input logic [15:0] lst, input logic [31:0] base,
                          input logic p, input logic u, input logic w,
                          input logic l, input bit poke);
    int n = 0;
    int ei [16];
    logic [31:0] ea [16];
    logic [31:0] snap [16];
    logic [31:0] sa, fa, span;
    string mtag;
    for (int i = 0; i < 16; i++) if (lst[i]) begin ei[n] = i; n++; end
    span = 32'(n * 4);
    if (u) begin sa = p ? base + 4 : base; fa = base + span; end
    else   begin sa = p ? base - span : base - span + 4; fa = base - span; end
    mtag = u ? (p ? "R5" : "R4") : (p ? "R7" : "R6");
    for (int k = 0; k < n; k++) begin
      ea[k]   = sa + 32'(k * 4);
      snap[k] = l ? bmem[ea[k][9:2]] : rfile[ei[k]];
    end

    @(negedge clk);
    start_i = 1'b1; reglist_i = lst; base_i = base;
    pre_i = p; up_i = u; wb_i = w; load_i = l;
    @(negedge clk);                       // after E0
    start_i = poke;
    if (poke) begin reglist_i = 16'hFFFF; base_i = 32'h0; load_i = ~l; wb_i = ~w; end
    check(busy_o == 1'b1, "R11 busy after start", 32'(busy_o), 1);
    check(mem_req_o == 1'b0 && rf_rd_o == 1'b0, "R11 no access at E0",
          32'({mem_req_o, rf_rd_o}), 0);

    for (int j = 1; j <= n + 1; j++) begin
      @(negedge clk);                     // after E(j)
      if (l) begin
        if (j <= n) begin
          check(mem_req_o && !mem_we_o, "R9 load read", 32'({mem_req_o, mem_we_o}), 32'b10);
          check(mem_addr_o == ea[j-1], (j == 1) ? mtag : "R3", mem_addr_o, ea[j-1]);
        end else begin
          check(!mem_req_o, "R2 no extra read", 32'(mem_req_o), 0);
        end
        if (j >= 2) begin
          check(rf_we_o == 1'b1, "R9 rf write", 32'(rf_we_o), 1);
          check(rf_widx_o == 4'(ei[j-2]), "R2 write index", 32'(rf_widx_o), 32'(ei[j-2]));
          check(rf_wdata_o == snap[j-2], "R9 write data", rf_wdata_o, snap[j-2]);
        end else begin
          check(!rf_we_o, "R9 no early write", 32'(rf_we_o), 0);
        end
      end else begin
        if (j <= n) begin
          check(rf_rd_o == 1'b1, "R10 rf read", 32'(rf_rd_o), 1);
          check(rf_ridx_o == 4'(ei[j-1]), "R2 read index", 32'(rf_ridx_o), 32'(ei[j-1]));
        end else begin
          check(!rf_rd_o, "R2 no extra rf read", 32'(rf_rd_o), 0);
        end
        if (j >= 2) begin
          check(mem_req_o && mem_we_o, "R10 mem write", 32'({mem_req_o, mem_we_o}), 32'b11);
          check(mem_addr_o == ea[j-2], (j == 2) ? mtag : "R3", mem_addr_o, ea[j-2]);
          check(mem_wdata_o == snap[j-2], "R10 write data", mem_wdata_o, snap[j-2]);
        end else begin
          check(!mem_req_o, "R10 no early mem write", 32'(mem_req_o), 0);
        end
      end
    end

    @(negedge clk);                       // after E(n+2)
    start_i = 1'b0;
    check(done_o == 1'b1, "R11 done", 32'(done_o), 1);
    check(busy_o == 1'b0, "R11 busy low at done", 32'(busy_o), 0);
    check(err_o == 1'b0, "R12 no err", 32'(err_o), 0);
    check(base_we_o == w, "R8 base_we", 32'(base_we_o), 32'(w));
    if (w) check(base_wdata_o == fa, "R8 base value", base_wdata_o, fa);
    check(mem_req_o == 1'b0 && rf_we_o == 1'b0, "R2 quiet at done",
          32'({mem_req_o, rf_we_o}), 0);

    @(negedge clk);                       // after E(n+3)
    check(done_o == 1'b0, "R11 done single", 32'(done_o), 0);
    check(busy_o == 1'b0, "R13 no restart", 32'(busy_o), 0);
    check(base_we_o == 1'b0, "R8 base_we single", 32'(base_we_o), 0);
    for (int k = 0; k < n; k++) begin
      if (l) check(rfile[ei[k]] == snap[k], "R9 loaded", rfile[ei[k]], snap[k]);
      else   check(bmem[ea[k][9:2]] == snap[k], "R10 stored", bmem[ea[k][9:2]], snap[k]);
    end
  endtask

  task automatic run_empty();
    @(negedge clk);
    start_i = 1'b1; reglist_i = 16'h0000; base_i = 32'h200;
    wb_i = 1'b1; load_i = 1'b1; up_i = 1'b1; pre_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1,  "R12 err", 32'(err_o), 1);
    check(done_o == 1'b1, "R12 done", 32'(done_o), 1);
    check(busy_o == 1'b0, "R12 busy", 32'(busy_o), 0);
    check(!mem_req_o && !rf_rd_o && !rf_we_o, "R12 no access",
          32'({mem_req_o, rf_rd_o, rf_we_o}), 0);
    check(base_we_o == 1'b0, "R12 no base write", 32'(base_we_o), 0);
    @(negedge clk);
    check(err_o == 1'b0 && done_o == 1'b0, "R12 single pulse", 32'({err_o, done_o}), 0);
    check(busy_o == 1'b0 && !mem_req_o, "R12 stays idle", 32'({busy_o, mem_req_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst = 1'b0;
    @(negedge clk);
    check_reset();
    run_xfer(16'h8421, 32'h100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R4 load
    run_xfer(16'h00F0, 32'h200, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R5 store
    run_xfer(16'hC003, 32'h300, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // R6 load
    run_xfer(16'h803A, 32'h380, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R7 store
    run_xfer(16'hFFFF, 32'h040, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R2 full list
    run_xfer(16'hFFFF, 32'h3C0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R7 full load
    run_xfer(16'h0001, 32'h180, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // single reg
    run_xfer(16'h0A50, 32'h120, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); // R13 poke
    run_empty();
    run_xfer(16'h4002, 32'h2A0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); // R13 poke
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule